// File: doc/BRIEF.md
# Memory Range Type Classifier

This block assigns a memory type to each 32-bit physical address it is handed. The type is uncacheable, write-combining or the default cacheable type. A single 64-bit control word defines two address ranges. Each range has a 15-bit base and a 15-bit mask that together cover address bits 31:17, so ranges are aligned to 128 KB. Each range also has two attribute flags. An address belongs to a range when the masked base equals the masked upper address bits. A range with neither flag set is switched off.

The control word is loaded and read back whole through a simple write/read port. Addresses arrive with a valid strobe. One clock later the block presents a registered result: a per-range hit vector and the resolved type. When the ranges overlap, or a range carries both flags, uncacheable wins over write-combining. The reset input is asserted asynchronously and released through an internal two-stage synchroniser, so the block leaves reset on the second rising clock edge after the reset pin goes high.

Top module: `mem_range_classifier`

## Requirements
- R1: After reset, `cfg_rdata` reads all zero, `res_valid`, `res_hit` and `res_type` are 0, and every address classifies as default (type code 0).
- R2: Range 0 is held in bits 31:0 of the control word and range 1 in bits 63:32. Within each 32-bit half, bit 0 is the uncacheable flag, bit 1 is the write-combining flag, bits 16:2 are the mask and bits 31:17 are the base.
- R3: An address is inside a range when (mask AND base) equals (mask AND address bits 31:17). Address bits 16:0 never affect the result.
- R4: A hit in a range with only its uncacheable flag set gives type code 2. A hit in a range with only its write-combining flag set gives type code 1. No hit gives type code 0. Code 3 never appears.
- R5: A range whose two flags are both 0 never hits, whatever its base and mask.
- R6: Uncacheable has priority. If an address hits both ranges and either hit range has its uncacheable flag set, or a hit range has both flags set, the type is 2.
- R7: `res_valid` follows `addr_valid` one clock later. In that cycle `res_hit[i]` shows whether range i matched. When `addr_valid` is low, `res_hit` and `res_type` keep their previous values.
- R8: A write with `cfg_we` high changes `cfg_rdata` and the classification of addresses sampled from the next clock edge onward. Addresses sampled at the same edge as the write still use the old word. Without a write, `cfg_rdata` stays unchanged.
- R9: A range with an all-zero mask and at least one flag set hits every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Write strobe for the 64-bit control word |
| cfg_wdata | input | 64 | Value written to the control word |
| cfg_rdata | output | 64 | Current control word |
| addr_valid | input | 1 | Address strobe |
| addr | input | 32 | Physical address to classify |
| res_valid | output | 1 | Result valid, one clock after `addr_valid` |
| res_hit | output | 2 | Per-range match flags |
| res_type | output | 2 | Resolved type: 0 default, 1 write-combining, 2 uncacheable |

## Verification
The hardest situation to reach from the ports is an address that matches both ranges at once, with a different attribute mix on each range and with partial masks. Random words and addresses almost never produce this. The bench therefore writes control words whose two bases agree on the masked bits and whose masks leave some bits free. It then picks addresses whose upper bits are copied from the base, with only the unmasked bits and the low 17 bits randomised. The same biased generator places writes in the same cycle as an address strobe, which exercises the old-word/new-word boundary.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [1:0] {
    MT_DEFAULT = 2'd0,
    MT_WC      = 2'd1,
    MT_UC      = 2'd2
  } mem_type_e;
endpackage

// File: rtl/mrc_rst_sync.sv
module mrc_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/mrc_cfg_reg.sv
module mrc_cfg_reg #(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] word_o
);
  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (we_i) word_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;

  // R8
  cfg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    we_i |=> (word_o == $past(wdata_i)));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !we_i |=> $stable(word_o));
endmodule

// File: rtl/mrc_range_match.sv
module mrc_range_match #(
  parameter int FIELD_W = 15
) (
  input  logic [2*FIELD_W+1:0] half_i,
  input  logic [FIELD_W-1:0]   addr_hi_i,
  output logic                 hit_o,
  output logic                 uc_o
);
  localparam int UC_POS   = 0;
  localparam int WC_POS   = 1;
  localparam int MASK_LSB = 2;
  localparam int BASE_LSB = MASK_LSB + FIELD_W;
  localparam int HALF_W   = BASE_LSB + FIELD_W;

  logic               flag_uc;
  logic               flag_wc;
  logic [FIELD_W-1:0] mask_f;
  logic [FIELD_W-1:0] base_f;
  logic               same;

  always_comb begin
    flag_uc = half_i[UC_POS];
    flag_wc = half_i[WC_POS];
    mask_f  = half_i[BASE_LSB-1:MASK_LSB];
    base_f  = half_i[HALF_W-1:BASE_LSB];
    same    = ((mask_f & base_f) == (mask_f & addr_hi_i));
    hit_o   = same && (flag_uc || flag_wc);
    uc_o    = flag_uc;
  end
endmodule

// File: rtl/mrc_resolve.sv
module mrc_resolve
  import mrc_pkg::*;
#(
  parameter int NUM_RANGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [NUM_RANGES-1:0] hit_i,
  input  logic [NUM_RANGES-1:0] uc_i,
  output logic                  res_valid_o,
  output logic [NUM_RANGES-1:0] res_hit_o,
  output mem_type_e             res_type_o
);
  logic                  valid_q;
  logic [NUM_RANGES-1:0] hit_q;
  logic [NUM_RANGES-1:0] hit_d;
  mem_type_e             type_q;
  mem_type_e             type_d;

  always_comb begin
    hit_d  = hit_q;
    type_d = type_q;
    if (valid_i) begin
      hit_d = hit_i;
      if ((hit_i & uc_i) != '0) type_d = MT_UC;
      else if (hit_i != '0)     type_d = MT_WC;
      else                      type_d = MT_DEFAULT;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hit_q   <= '0;
      type_q  <= MT_DEFAULT;
    end else begin
      valid_q <= valid_i;
      hit_q   <= hit_d;
      type_q  <= type_d;
    end
  end

  assign res_valid_o = valid_q;
  assign res_hit_o   = hit_q;
  assign res_type_o  = type_q;

  // R7
  res_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_i |=> res_valid_o);

  // R7
  res_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !valid_i |=> (!res_valid_o && $stable(res_hit_o) && $stable(res_type_o)));

  // R6
  uc_priority_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && ((hit_i & uc_i) != '0)) |=> (res_type_o == MT_UC));

  // R4
  no_hit_default_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && (hit_i == '0)) |=> (res_type_o == MT_DEFAULT));

  // R4
  type_legal_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    res_type_o != 2'd3);
endmodule

// File: rtl/mem_range_classifier.sv
module mem_range_classifier
  import mrc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIELD_W    = 15,
  parameter int NUM_RANGES = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [NUM_RANGES*(2*FIELD_W+2)-1:0]   cfg_wdata,
  output logic [NUM_RANGES*(2*FIELD_W+2)-1:0]   cfg_rdata,
  input  logic                                  addr_valid,
  input  logic [ADDR_W-1:0]                     addr,
  output logic                                  res_valid,
  output logic [NUM_RANGES-1:0]                 res_hit,
  output logic [1:0]                            res_type
);
  localparam int HALF_W = 2 * FIELD_W + 2;
  localparam int REG_W  = NUM_RANGES * HALF_W;
  localparam int GRAN_W = ADDR_W - FIELD_W;

  logic                  rst_sync_n;
  logic [REG_W-1:0]      cfg_q;
  logic [NUM_RANGES-1:0] rng_hit;
  logic [NUM_RANGES-1:0] rng_uc;
  logic [FIELD_W-1:0]    addr_hi;
  logic                  unused_low_bits;
  mem_type_e             type_w;

  assign addr_hi         = addr[ADDR_W-1:GRAN_W];
  assign unused_low_bits = ^addr[GRAN_W-1:0];

  mrc_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  mrc_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .word_o  (cfg_q)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
    mrc_range_match #(.FIELD_W(FIELD_W)) u_match (
      .half_i    (cfg_q[g*HALF_W +: HALF_W]),
      .addr_hi_i (addr_hi),
      .hit_o     (rng_hit[g]),
      .uc_o      (rng_uc[g])
    );
  end

  mrc_resolve #(.NUM_RANGES(NUM_RANGES)) u_res (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .valid_i     (addr_valid),
    .hit_i       (rng_hit),
    .uc_i        (rng_uc),
    .res_valid_o (res_valid),
    .res_hit_o   (res_hit),
    .res_type_o  (type_w)
  );

  assign cfg_rdata = cfg_q;
  assign res_type  = type_w;

  // R5
  no_flag_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_valid && (cfg_q[1:0] == 2'b00)) |=> !res_hit[0]);

  // R9
  zero_mask_hits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_valid && (cfg_q[1:0] != 2'b00) && (cfg_q[FIELD_W+1:2] == '0)) |=> res_hit[0]);
endmodule

// File: tb/tb_mem_range_classifier.sv
module tb_mem_range_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        addr_valid = 1'b0;
  logic [31:0] addr = '0;
  logic        res_valid;
  logic [1:0]  res_hit;
  logic [1:0]  res_type;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  logic [63:0] m_word = '0;
  logic        e_valid = 1'b0;
  logic [1:0]  e_hit = '0;
  logic [1:0]  e_type = '0;

  always #10 clk = ~clk;

  mem_range_classifier dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .addr_valid(addr_valid), .addr(addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_type(res_type)
  );

  function automatic logic [31:0] mkhalf(bit uc, bit wc, int mask, int base);
    logic [14:0] m = mask[14:0];
    logic [14:0] b = base[14:0];
    return {b, m, wc, uc};
  endfunction

  // Behavioural model of the requirements: returns hit vector and type code.
  function automatic void classify(input logic [63:0] w, input logic [31:0] a,
                                   output logic [1:0] h, output logic [1:0] t);
    bit any_uc = 0;
    h = '0;
    for (int i = 0; i < 2; i++) begin
      int half = int'(w[32*i +: 32]);
      int upper = int'(a >> 17);
      int mk = (half >> 2) & 32'h7fff;
      int bs = (half >> 17) & 32'h7fff;
      bit uc = half[0];
      bit wc = half[1];
      if ((uc || wc) && ((mk & bs) == (mk & upper))) begin
        h[i] = 1'b1;
        if (uc) any_uc = 1;
      end
    end
    if (any_uc) t = 2'd2;
    else if (h != 0) t = 2'd1;
    else t = 2'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = '0; e_valid = 0; e_hit = '0; e_type = '0;
    end else begin
      e_valid = addr_valid;
      if (addr_valid) classify(m_word, addr, e_hit, e_type);
      if (cfg_we) m_word = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (cfg_rdata !== m_word) begin
        miscompares++;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, cfg_rdata, m_word);
      end
      if (res_valid !== e_valid || res_hit !== e_hit || res_type !== e_type) begin
        miscompares++;
        $display("FAIL %s result actual v=%0b h=%b t=%0d expected v=%0b h=%b t=%0d",
                 cur_req, res_valid, res_hit, res_type, e_valid, e_hit, e_type);
      end
    end
  end

  task automatic step(bit we, logic [63:0] wd, bit v, logic [31:0] a);
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; addr_valid = v; addr = a;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 64'h0, 0, 32'h0);
  endtask

  task automatic explicit_check(string req, logic [1:0] h, logic [1:0] t);
    @(negedge clk);
    #1;
    vectors++;
    if (res_hit !== h || res_type !== t) begin
      miscompares++;
      $display("FAIL %s explicit actual h=%b t=%0d expected h=%b t=%0d", req, res_hit, res_type, h, t);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state and default classification
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    step(0, 0, 1, 32'h0000_0000);
    step(0, 0, 1, 32'hffff_ffff);
    explicit_check("R1", 2'b00, 2'd0);
    step(0, 0, 1, 32'h1234_5678);
    idle(1);

    // R2, R4: range 0 uncacheable at upper 0x0010, range 1 write-combining at 0x0300
    cur_req = "R2";
    step(1, {mkhalf(0, 1, 15'h7fff, 15'h0300), mkhalf(1, 0, 15'h7fff, 15'h0010)}, 0, 0);
    step(0, 0, 1, 32'h0020_0000);
    explicit_check("R4", 2'b01, 2'd2);
    cur_req = "R4";
    step(0, 0, 1, 32'h0600_1234);
    explicit_check("R4", 2'b10, 2'd1);
    step(0, 0, 1, 32'h0040_0000);
    idle(1);

    // R3: low 17 bits ignored, partial masks
    cur_req = "R3";
    step(0, 0, 1, 32'h0021_ffff);
    step(0, 0, 1, 32'h0020_0001);
    step(1, {mkhalf(0, 1, 15'h7f00, 15'h0300), mkhalf(1, 0, 15'h00ff, 15'h0010)}, 0, 0);
    step(0, 0, 1, {15'h5a10, 17'h1abcd});
    explicit_check("R3", 2'b01, 2'd2);
    step(0, 0, 1, {15'h0311, 17'h0});
    step(0, 0, 1, {15'h0411, 17'h0});
    idle(1);

    // R5: flags cleared, base matches
    cur_req = "R5";
    step(1, {mkhalf(0, 0, 15'h7fff, 15'h0010), mkhalf(0, 0, 15'h0000, 15'h0010)}, 0, 0);
    step(0, 0, 1, 32'h0020_0000);
    explicit_check("R5", 2'b00, 2'd0);
    step(0, 0, 1, 32'hdead_beef);
    idle(1);

    // R6: overlap, and both flags in one range
    cur_req = "R6";
    step(1, {mkhalf(1, 0, 15'h7fff, 15'h0010), mkhalf(0, 1, 15'h7fff, 15'h0010)}, 0, 0);
    step(0, 0, 1, 32'h0020_0000);
    explicit_check("R6", 2'b11, 2'd2);
    step(1, {mkhalf(0, 0, 15'h0, 15'h0), mkhalf(1, 1, 15'h7fff, 15'h0010)}, 0, 0);
    step(0, 0, 1, 32'h0020_0000);
    explicit_check("R6", 2'b01, 2'd2);

    // R7: gaps in the strobe, outputs hold
    cur_req = "R7";
    step(0, 0, 0, 32'hffff_ffff);
    step(0, 0, 0, 32'h0000_0000);
    step(0, 0, 1, 32'h4000_0000);
    step(0, 0, 0, 32'h0020_0000);
    step(0, 0, 1, 32'h0020_0000);
    idle(2);

    // R8: write and strobe at the same edge, then next edge
    cur_req = "R8";
    step(1, {32'h0, mkhalf(0, 1, 15'h7fff, 15'h1000)}, 1, 32'h2000_0000);
    step(0, 0, 1, 32'h2000_0000);
    explicit_check("R8", 2'b01, 2'd1);
    idle(2);

    // R9: zero mask on range 1 hits everything
    cur_req = "R9";
    step(1, {mkhalf(0, 1, 15'h0, 15'h1234), 32'h0}, 0, 0);
    step(0, 0, 1, 32'h0000_0000);
    step(0, 0, 1, 32'hffff_ffff);
    explicit_check("R9", 2'b10, 2'd1);
    step(0, 0, 1, 32'h8765_4321);
    idle(1);

    // Biased random mix over all requirements
    cur_req = "R3/R6/R8 random";
    for (int n = 0; n < 4000; n++) begin
      bit          we = ($urandom_range(0, 7) == 0);
      logic [63:0] wd = {$urandom, $urandom};
      logic [14:0] bs = m_word[31:17];
      logic [14:0] mk = m_word[16:2];
      logic [31:0] a  = $urandom;
      if ($urandom_range(0, 3) == 0) wd[16:2] = '0;
      if ($urandom_range(0, 3) != 0) begin
        wd[63:49] = (wd[31:17] & wd[48:34]) | (wd[63:49] & ~wd[48:34]);
        if ($urandom_range(0, 1) == 0) wd[48:34] = wd[16:2];
      end
      if ($urandom_range(0, 2) != 0) a[31:17] = (bs & mk) | (a[31:17] & ~mk);
      step(we, wd, $urandom_range(0, 4) != 0, a);
    end
    idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule